// File: doc/BRIEF.md
# Static Tamper Pin Alarm Filter

This block guards one tamper-sense pin. The pin passes through a synchronizer and is sampled once on each cycle that the sample-enable tick is high. Each sample is classed against a programmed idle level. A sample at the idle level is good, and a sample at the other level is bad. Bad samples add to an alarm counter. When the count reaches a limit chosen by a 4-bit power-of-two code, a sticky alarm flag is set. A second counter measures runs of consecutive good samples. When a run reaches its own coded limit, the alarm counter is wiped. Brief noise is therefore forgiven, but a pin that stays disturbed raises the alarm.

Detection stops, and both counters are held at zero, while the pin is in output mode, while the dynamic-signature mode is selected, or while the alarm code is zero. The flag is held until software pulses the clear input. Any change to the idle level or to either code restarts the counting.

Top module: `tamper_static_filter`

## Requirements
- R1: After reset, `alarm_flag` is 0 and both counters are zero. With the reset values of the inputs (codes 0, input mode, idle low), bad samples never raise the flag.
- R2: A sample is bad when the synchronized pin differs from `idle_high` (0 = idle low, 1 = idle high). Otherwise it is good. Only bad samples advance the alarm count.
- R3: For an `alarm_code` n from 1 to 9, the flag is set on the clock edge that takes the 2^n-th counted bad sample, and not earlier.
- R4: `alarm_code` values 10 to 15 act as code 9, so the limit is 512 bad samples.
- R5: `alarm_code` 0 turns static detection off. The flag is never set and both counters stay at zero.
- R6: For a `rearm_code` m from 1 to 15 (10 to 15 act as 9), 2^m consecutive good samples clear the alarm counter.
- R7: A bad sample restarts the good-run count at zero, so good samples that are broken by a bad one do not clear the alarm counter.
- R8: With `rearm_code` 0, good samples never clear the alarm counter, and bad samples build up until the flag is set.
- R9: While `out_mode` or `dyn_mode` is 1, no sample is counted and both counters are zeroed on every clock. The flag keeps its value.
- R10: `alarm_flag` stays set until `alarm_clr` is high for a cycle. The next edge then clears the flag and both counters. The clear wins over a sample taken in the same cycle.
- R11: A change to `idle_high`, `alarm_code` or `rearm_code` zeroes both counters on the next clock edge. A sample taken in that cycle is dropped.
- R12: Samples are taken only on cycles where `tick_en` is 1. The pin goes through a 2-flop synchronizer, so a sample sees the pin level from two clocks earlier.
- R13: Neither counter goes above its decoded limit while the configuration is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Sample enable, one cycle per sample |
| pin_in | input | 1 | Asynchronous tamper-sense pin level |
| idle_high | input | 1 | Idle (good) pin level: 0 low, 1 high |
| out_mode | input | 1 | Pin configured as output; disables detection |
| dyn_mode | input | 1 | Dynamic-signature mode selected; disables detection |
| alarm_code | input | 4 | Alarm limit code: 0 off, n gives 2^n, 10 to 15 give 512 |
| rearm_code | input | 4 | Good-run limit code: 0 never clears, n gives 2^n, 10 to 15 give 512 |
| alarm_clr | input | 1 | One-cycle clear of the flag and both counters |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The assertions assume that `alarm_clr` is a single-cycle pulse. They also assume that a limit bound on a counter is only meaningful in cycles where the configuration has not just changed, because a code that drops can leave an old count above the new limit for one edge. The stimulus holds the pin steady for three clocks before each tick, so the synchronized value is the intended one. The only exception is one directed case that changes the pin and the tick together to show the synchronizer delay. Configuration changes are made only through a task that waits a full clock before the next sample, and clears are single-cycle pulses between samples.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    parameter int TSF_CODE_W   = 4;
    parameter int TSF_MAX_CODE = 9;
    parameter int TSF_CNT_W    = TSF_MAX_CODE + 1;
    parameter int TSF_SYNC_LEN = 2;

    // Static configuration that restarts counting when any field moves
    typedef struct packed {
        logic                  idle_high;
        logic [TSF_CODE_W-1:0] alarm_code;
        logic [TSF_CODE_W-1:0] rearm_code;
    } tsf_cfg_t;

    // Classification of the current cycle's sample
    typedef enum logic [1:0] {
        SMP_NONE = 2'd0,
        SMP_GOOD = 2'd1,
        SMP_BAD  = 2'd2
    } tsf_smp_e;

    // Power-of-two limit from a code; 0 means no limit, codes above the
    // maximum saturate to the largest limit.
    function automatic logic [TSF_CNT_W-1:0] tsf_code_to_limit(
        input logic [TSF_CODE_W-1:0] code
    );
        logic [TSF_CODE_W-1:0] shift;
        if (code == '0) begin
            return '0;
        end
        shift = (int'(code) > TSF_MAX_CODE) ? TSF_CODE_W'(TSF_MAX_CODE) : code;
        return TSF_CNT_W'(1) << shift;
    endfunction

endpackage

// File: rtl/tsf_pin_sampler.sv
module tsf_pin_sampler
    import tsf_pkg::*;
#(
    parameter int STAGES = TSF_SYNC_LEN
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_in,
    input  logic     take,
    input  logic     idle_high,
    output tsf_smp_e smp
);

    logic pin_sync;

    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= pin_in;
            end
            assign pin_sync = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], pin_in};
            end
            assign pin_sync = chain_q[STAGES-1];
        end
    endgenerate

    always_comb begin
        if (!take)                     smp = SMP_NONE;
        else if (pin_sync != idle_high) smp = SMP_BAD;
        else                           smp = SMP_GOOD;
    end

endmodule

// File: rtl/tsf_limit_dec.sv
module tsf_limit_dec
    import tsf_pkg::*;
#(
    parameter int CODE_W = TSF_CODE_W,
    parameter int CNT_W  = TSF_CNT_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit
);

    always_comb begin
        limit = CNT_W'(tsf_code_to_limit(TSF_CODE_W'(code)));
    end

endmodule

// File: rtl/tsf_sat_counter.sv
module tsf_sat_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         hit
);

    logic [W:0] next_val;
    logic       headroom;

    assign next_val = {1'b0, count} + {{W{1'b0}}, 1'b1};
    assign headroom = count < limit;
    assign hit      = inc && (limit != '0) && (next_val >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr)          count <= '0;
        else if (inc && headroom) count <= next_val[W-1:0];
    end

endmodule

// File: rtl/tamper_static_filter.sv
module tamper_static_filter
    import tsf_pkg::*;
#(
    parameter int CODE_W = TSF_CODE_W,
    parameter int CNT_W  = TSF_CNT_W,
    parameter int SYNC_N = TSF_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              pin_in,
    input  logic              idle_high,
    input  logic              out_mode,
    input  logic              dyn_mode,
    input  logic [CODE_W-1:0] alarm_code,
    input  logic [CODE_W-1:0] rearm_code,
    input  logic              alarm_clr,
    output logic              alarm_flag
);

    localparam int N_LIM = 2;

    tsf_cfg_t   cfg_now, cfg_q;
    logic       cfg_change;
    logic       active;
    logic       clear_all;
    logic       take;
    tsf_smp_e   smp;

    logic [N_LIM-1:0][CODE_W-1:0] codes;
    logic [N_LIM-1:0][CNT_W-1:0]  limits;
    logic [CNT_W-1:0]             a_lim, v_lim;
    logic [CNT_W-1:0]             a_cnt, v_cnt;
    logic                         a_hit, v_hit;

    // Configuration tracking (R11)
    assign cfg_now = '{idle_high:  idle_high,
                       alarm_code: TSF_CODE_W'(alarm_code),
                       rearm_code: TSF_CODE_W'(rearm_code)};

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_now;
    end

    assign cfg_change = (cfg_now != cfg_q);
    assign active     = !out_mode && !dyn_mode && (alarm_code != '0);
    assign clear_all  = alarm_clr || cfg_change || !active;
    assign take       = tick_en && !clear_all;

    // Limit decoding for both codes
    assign codes[0] = alarm_code;
    assign codes[1] = rearm_code;

    generate
        for (genvar g = 0; g < N_LIM; g++) begin : g_dec
            tsf_limit_dec #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
                .code  (codes[g]),
                .limit (limits[g])
            );
        end
    endgenerate

    assign a_lim = limits[0];
    assign v_lim = limits[1];

    tsf_pin_sampler #(.STAGES(SYNC_N)) u_smp (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .take      (take),
        .idle_high (idle_high),
        .smp       (smp)
    );

    // Alarm counter: bad samples; wiped by a full good run
    tsf_sat_counter #(.W(CNT_W)) u_alarm_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clear_all || v_hit),
        .inc   (smp == SMP_BAD),
        .limit (a_lim),
        .count (a_cnt),
        .hit   (a_hit)
    );

    // Good-run counter: restarted by any bad sample
    tsf_sat_counter #(.W(CNT_W)) u_valid_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clear_all || (smp == SMP_BAD)),
        .inc   (smp == SMP_GOOD),
        .limit (v_lim),
        .count (v_cnt),
        .hit   (v_hit)
    );

    // Sticky flag (R10)
    always_ff @(posedge clk) begin
        if (rst)            alarm_flag <= 1'b0;
        else if (alarm_clr) alarm_flag <= 1'b0;
        else if (a_hit)     alarm_flag <= 1'b1;
    end

endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             alarm_clr,
    input logic             alarm_flag,
    input logic             active,
    input logic             cfg_change,
    input logic [CNT_W-1:0] a_cnt,
    input logic [CNT_W-1:0] a_lim,
    input logic [CNT_W-1:0] v_cnt,
    input logic [CNT_W-1:0] v_lim
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!alarm_flag && a_cnt == '0 && v_cnt == '0));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
        alarm_clr |=> (!alarm_flag && a_cnt == '0 && v_cnt == '0));

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !alarm_clr) |=> alarm_flag);

    p_rise_on_tick_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> ($past(tick_en) && $past(active)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !active |=> (a_cnt == '0 && v_cnt == '0));

    p_cfg_restart_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_change |=> (a_cnt == '0 && v_cnt == '0));

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (rst)
        !cfg_change |-> (a_cnt <= a_lim && v_cnt <= v_lim));

endmodule

bind tamper_static_filter tsf_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .alarm_clr  (alarm_clr),
    .alarm_flag (alarm_flag),
    .active     (active),
    .cfg_change (cfg_change),
    .a_cnt      (a_cnt),
    .a_lim      (a_lim),
    .v_cnt      (v_cnt),
    .v_lim      (v_lim)
);

// File: tb/tamper_static_filter_test.sv
module tamper_static_filter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       pin_in = 1'b0;
    logic       idle_high = 1'b0;
    logic       out_mode = 1'b0;
    logic       dyn_mode = 1'b0;
    logic [3:0] alarm_code = 4'd0;
    logic [3:0] rearm_code = 4'd0;
    logic       alarm_clr = 1'b0;
    logic       alarm_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state
    int  m_acnt = 0;
    int  m_vcnt = 0;
    bit  m_flag = 1'b0;

    always #2 clk = ~clk;

    tamper_static_filter uut (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .pin_in     (pin_in),
        .idle_high  (idle_high),
        .out_mode   (out_mode),
        .dyn_mode   (dyn_mode),
        .alarm_code (alarm_code),
        .rearm_code (rearm_code),
        .alarm_clr  (alarm_clr),
        .alarm_flag (alarm_flag)
    );

    function automatic int lim_of(input logic [3:0] code);
        if (code == 4'd0) return 0;
        if (code > 4'd9)  return 512;
        return 1 << code;
    endfunction

    function automatic bit is_active();
        return !out_mode && !dyn_mode && (alarm_code != 4'd0);
    endfunction

    task automatic check(input string req, input bit got, input bit exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: alarm_flag=%0b expected=%0b (t=%0t)", req, got, exp, $time);
        end
    endtask

    // Apply one sample to the model
    task automatic model_sample(input bit level);
        int alim, rlim;
        if (!is_active()) begin
            m_acnt = 0; m_vcnt = 0;
            return;
        end
        alim = lim_of(alarm_code);
        rlim = lim_of(rearm_code);
        if (level != idle_high) begin
            m_vcnt = 0;
            if (m_acnt < alim) m_acnt++;
            if (m_acnt >= alim) m_flag = 1'b1;
        end else if (rlim != 0) begin
            if (m_vcnt < rlim) m_vcnt++;
            if (m_vcnt >= rlim) m_acnt = 0;
        end
    endtask

    // Pin held for three clocks, then a single tick
    task automatic sample(input bit level, input string req);
        pin_in = level;
        repeat (3) @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        model_sample(level);
        check(req, alarm_flag, m_flag);
    endtask

    task automatic set_cfg(input bit idl, input logic [3:0] ac, input logic [3:0] rc,
                           input bit om, input bit dm);
        bit changed;
        changed = (idl != idle_high) || (ac != alarm_code) || (rc != rearm_code);
        idle_high = idl; alarm_code = ac; rearm_code = rc;
        out_mode = om; dyn_mode = dm;
        @(negedge clk);
        if (changed || !is_active()) begin
            m_acnt = 0; m_vcnt = 0;
        end
    endtask

    task automatic pulse_clr(input string req);
        alarm_clr = 1'b1;
        @(negedge clk);
        alarm_clr = 1'b0;
        m_flag = 1'b0; m_acnt = 0; m_vcnt = 0;
        check(req, alarm_flag, 1'b0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_0477));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", alarm_flag, 1'b0);
        for (int i = 0; i < 6; i++) sample(1'b1, "R1 reset codes");

        // R3: code 1 needs exactly two bad samples
        set_cfg(1'b0, 4'd1, 4'd0, 1'b0, 1'b0);
        sample(1'b1, "R3 first bad");
        check("R3 not early", alarm_flag, 1'b0);
        sample(1'b1, "R3 second bad");
        check("R3 limit 2", alarm_flag, 1'b1);
        for (int i = 0; i < 3; i++) sample(1'b0, "R10 sticky");
        check("R10 held", alarm_flag, 1'b1);
        pulse_clr("R10 clear");
        sample(1'b1, "R10 counters zeroed");
        check("R10 one bad after clear", alarm_flag, 1'b0);
        pulse_clr("R10 clear");

        // R2: idle high, low level is bad
        set_cfg(1'b1, 4'd2, 4'd0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) sample(1'b1, "R2 idle level ignored");
        for (int i = 0; i < 3; i++) sample(1'b0, "R2 bad low");
        check("R2 three bad", alarm_flag, 1'b0);
        sample(1'b0, "R2 fourth bad");
        check("R2 limit 4", alarm_flag, 1'b1);
        pulse_clr("R10 clear");

        // R6 / R7: alarm 8, good run 4
        set_cfg(1'b0, 4'd3, 4'd2, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) sample(1'b1, "R6 bad");
        for (int i = 0; i < 4; i++) sample(1'b0, "R6 good run");
        for (int i = 0; i < 7; i++) sample(1'b1, "R6 bad after wipe");
        check("R6 wiped count", alarm_flag, 1'b0);
        sample(1'b1, "R6 eighth bad");
        check("R6 limit 8", alarm_flag, 1'b1);
        pulse_clr("R10 clear");
        for (int i = 0; i < 6; i++) sample(1'b1, "R7 bad");
        for (int i = 0; i < 3; i++) sample(1'b0, "R7 short run");
        sample(1'b1, "R7 bad breaks run");
        for (int i = 0; i < 3; i++) sample(1'b0, "R7 short run");
        sample(1'b1, "R7 eighth bad");
        check("R7 broken runs do not wipe", alarm_flag, 1'b1);
        pulse_clr("R10 clear");

        // R8: no good-run limit
        set_cfg(1'b0, 4'd2, 4'd0, 1'b0, 1'b0);
        sample(1'b1, "R8 bad");
        for (int i = 0; i < 20; i++) sample(1'b0, "R8 good");
        sample(1'b1, "R8 bad");
        sample(1'b0, "R8 good");
        sample(1'b1, "R8 bad");
        check("R8 three bad", alarm_flag, 1'b0);
        sample(1'b1, "R8 fourth bad");
        check("R8 accumulates", alarm_flag, 1'b1);
        pulse_clr("R10 clear");

        // R5: code 0 disables
        set_cfg(1'b0, 4'd0, 4'd1, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) sample(1'b1, "R5 off");
        check("R5 no alarm", alarm_flag, 1'b0);

        // R9: output mode and dynamic mode
        set_cfg(1'b0, 4'd1, 4'd0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) sample(1'b1, "R9 output mode");
        check("R9 output mode", alarm_flag, 1'b0);
        set_cfg(1'b0, 4'd1, 4'd0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) sample(1'b1, "R9 dynamic mode");
        check("R9 dynamic mode", alarm_flag, 1'b0);
        set_cfg(1'b0, 4'd2, 4'd0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) sample(1'b1, "R9 bad");
        set_cfg(1'b0, 4'd2, 4'd0, 1'b0, 1'b1);
        set_cfg(1'b0, 4'd2, 4'd0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) sample(1'b1, "R9 bad after pause");
        check("R9 counters zeroed", alarm_flag, 1'b0);
        sample(1'b1, "R9 fourth bad");
        check("R9 fresh limit", alarm_flag, 1'b1);
        pulse_clr("R10 clear");

        // R11: configuration change restarts
        for (int i = 0; i < 3; i++) sample(1'b1, "R11 bad");
        set_cfg(1'b0, 4'd2, 4'd5, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) sample(1'b1, "R11 bad after change");
        check("R11 restart", alarm_flag, 1'b0);
        sample(1'b1, "R11 fourth bad");
        check("R11 fresh limit", alarm_flag, 1'b1);
        pulse_clr("R10 clear");

        // R12: no tick, no sample; synchronizer delay
        set_cfg(1'b0, 4'd1, 4'd0, 1'b0, 1'b0);
        pin_in = 1'b1;
        repeat (12) @(negedge clk);
        check("R12 no tick", alarm_flag, 1'b0);
        sample(1'b1, "R12 bad");
        sample(1'b0, "R12 good");
        pin_in = 1'b1;
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        model_sample(1'b0);
        check("R12 sync delay", alarm_flag, 1'b0);
        sample(1'b1, "R12 second bad");
        check("R12 second bad", alarm_flag, 1'b1);
        pulse_clr("R10 clear");

        // R4: reserved code gives 512
        set_cfg(1'b0, 4'd12, 4'd0, 1'b0, 1'b0);
        for (int i = 0; i < 511; i++) sample(1'b1, "R4 bad");
        check("R4 511 bad", alarm_flag, 1'b0);
        sample(1'b1, "R4 512th bad");
        check("R4 limit 512", alarm_flag, 1'b1);
        pulse_clr("R10 clear");

        // Random mix checked against the model (R2 R3 R6 R7 R13)
        for (int i = 0; i < 2500; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 8) begin
                set_cfg(1'($urandom_range(0, 1)),
                        4'($urandom_range(0, 5)),
                        4'($urandom_range(0, 4)),
                        ($urandom_range(0, 7) == 0),
                        ($urandom_range(0, 7) == 0));
            end else if (r < 11) begin
                pulse_clr("R10 random clear");
            end else begin
                sample(($urandom_range(0, 9) < 6) ? ~idle_high : idle_high,
                       "R13 random");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule